// File: doc/BRIEF.md
# Cascadable Eight-Level Priority Interrupt Controller

This block collects eight interrupt request lines, records them, applies a per-line mask and picks the most urgent one under a fixed priority order. It raises a single interrupt output toward the processor. On an acknowledge strobe it returns an 8-bit vector that identifies the chosen line, and it marks that line as in service until software retires it. Software reaches the block through a two-address register port. Address 0 is the command address and address 1 is the data address. Reads are combinational.

After a start command, three writes to the data address configure the block: the vector base, the cascade word and the mode word. Two copies can be chained. A slave drives one input of a master. When the master grants that input, it puts the input number on a cascade code bus during the acknowledge cycle, and the slave whose identity matches supplies the vector. The role of each copy is fixed by the `IS_MASTER` parameter.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF at the data address. The request and in-service registers are 0, `int_out` is low, and a command-address read returns the request register.
- R2: A command-address write with bit 4 set starts configuration. The next three data-address writes are taken in this order: vector base, cascade word, mode word. The start command clears the in-service register and selects the request register for reads. It leaves the mask register unchanged.
- R3: The returned vector is the upper five bits of the vector base with the 3-bit level number in the low three bits.
- R4: A data-address write outside configuration loads the mask register, and a data-address read returns it. A set mask bit keeps its line from raising `int_out`, but the request is still recorded in the request register.
- R5: Priority is fixed, with level 0 the highest. A request is presented only if it is unmasked and of strictly higher priority than every in-service bit.
- R6: When a line's `level_en` bit is 0, its request latches on a rising edge. The request clears when the line falls or at acknowledge. A line that stays high does not request again after acknowledge.
- R7: When a line's `level_en` bit is 1, its request follows the line. It therefore requests again after its in-service bit is retired, for as long as the line stays high.
- R8: An `ack` pulse while `int_out` is high clears the granted request bit and sets its in-service bit. In the following cycle, `vector_valid` is high for one cycle together with the vector.
- R9: When bit 1 of the mode word is set (automatic end of interrupt), acknowledge sets no in-service bit.
- R10: A command-address write whose bits 7:5 are 011, with bit 4 at 0, bit 3 at 0 and the level in bits 2:0 (0x60 plus the level), clears only that level's in-service bit.
- R11: A command-address write of 0x0A selects the request register for command-address reads, and 0x0B selects the in-service register. The selection holds across other accesses until it is changed.
- R12: An acknowledge with no request presented returns the base with level 7 and changes no in-service bit. This happens even when level 7 is masked.
- R13: On a master, a granted input whose cascade-word bit is set produces the input number on `cas_out` with `cas_valid` during the acknowledge cycle, and the master produces no vector. A slave whose cascade word (the identity, bits 2:0) matches that code returns its own vector and sets its own in-service bit. Each of the two copies then needs its own specific end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| addr | input | 1 | 0 selects the command address, 1 selects the data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current `addr` (combinational) |
| irq_in | input | 8 | Interrupt request lines |
| level_en | input | 8 | Per-line level-trigger enable |
| int_out | output | 1 | Interrupt request toward the processor |
| ack | input | 1 | Acknowledge strobe, one cycle |
| vector | output | 8 | Returned vector |
| vector_valid | output | 1 | Vector valid, one cycle after acknowledge |
| cas_in | input | 3 | Cascade code from the master (used on a slave) |
| cas_sel | input | 1 | Cascade code valid (used on a slave) |
| cas_out | output | 3 | Cascade code driven by a master |
| cas_valid | output | 1 | Cascade code valid, during the acknowledge cycle |

## Verification
On every cycle, the checker confirms the following. `int_out` never rises without an unmasked recorded request. In-service bits appear only after an acknowledge, and never in automatic mode. A specific end-of-interrupt removes exactly one in-service bit. An acknowledge without a presented request always yields the level-7 vector. The bench scenarios cover the behaviours a single-cycle property cannot express: the order of the configuration words, the nesting of priorities against in-service levels, and edge versus level re-requesting. They also cover the persistence of the read selection and the two-copy cascade hand-off with its pair of end-of-interrupt writes.

// File: rtl/pic_pkg.sv
package pic_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_BASE,
      SEQ_CASC,
      SEQ_MODE
   } seq_e;

   // command-address bit fields
   localparam int         CMD_START_BIT = 4;
   localparam int         CMD_RSEL_BIT  = 3;
   localparam int         RSEL_EN_BIT   = 1;
   localparam int         RSEL_ISR_BIT  = 0;
   localparam logic [2:0] EOI_OPCODE    = 3'b011;

   // mode word
   localparam int         MODE_AUTO_BIT = 1;

   localparam logic       ADDR_CMD  = 1'b0;
   localparam logic       ADDR_DATA = 1'b1;

endpackage

// File: rtl/pic_regport.sv
module pic_regport
   import pic_pkg::*;
#(
   parameter int              DW       = 8,
   parameter logic [DW-1:0]   RST_MASK = '1,
   localparam int             LVL_W    = $clog2(DW),
   localparam int             BASE_W   = DW - LVL_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               addr,
   input  logic [DW-1:0]      wdata,
   output logic [DW-1:0]      imr_q,
   output logic [BASE_W-1:0]  base_q,
   output logic [DW-1:0]      casc_q,
   output logic               auto_q,
   output logic               rd_isr_q,
   output logic               eoi_stb,
   output logic [LVL_W-1:0]   eoi_lvl,
   output logic               init_stb
);

   seq_e  seq_q;
   logic  cmd_wr;
   logic  data_wr;

   assign cmd_wr   = wr_en && (addr == ADDR_CMD);
   assign data_wr  = wr_en && (addr == ADDR_DATA);
   assign init_stb = cmd_wr && wdata[CMD_START_BIT];
   assign eoi_stb  = cmd_wr && !wdata[CMD_START_BIT] && !wdata[CMD_RSEL_BIT]
                     && (wdata[DW-1:DW-3] == EOI_OPCODE);
   assign eoi_lvl  = wdata[LVL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q    <= SEQ_IDLE;
         imr_q    <= RST_MASK;
         base_q   <= '0;
         casc_q   <= '0;
         auto_q   <= 1'b0;
         rd_isr_q <= 1'b0;
      end else begin
         if (init_stb) begin
            seq_q    <= SEQ_BASE;
            rd_isr_q <= 1'b0;
         end else if (cmd_wr && wdata[CMD_RSEL_BIT] && wdata[RSEL_EN_BIT]) begin
            rd_isr_q <= wdata[RSEL_ISR_BIT];
         end
         if (data_wr) begin
            unique case (seq_q)
               SEQ_BASE: begin
                  base_q <= wdata[DW-1:LVL_W];
                  seq_q  <= SEQ_CASC;
               end
               SEQ_CASC: begin
                  casc_q <= wdata;
                  seq_q  <= SEQ_MODE;
               end
               SEQ_MODE: begin
                  auto_q <= wdata[MODE_AUTO_BIT];
                  seq_q  <= SEQ_IDLE;
               end
               default: imr_q <= wdata;
            endcase
         end
      end
   end

endmodule

// File: rtl/pic_req_capture.sv
module pic_req_capture #(
   parameter int N = 8
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  irq_in,
   input  logic [N-1:0]  level_en,
   input  logic [N-1:0]  clr_vec,
   output logic [N-1:0]  irr_q
);

   logic [N-1:0] prev_q;

   for (genvar g = 0; g < N; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q[g] <= 1'b0;
            irr_q[g]  <= 1'b0;
         end else begin
            prev_q[g] <= irq_in[g];
            if (clr_vec[g])
               irr_q[g] <= 1'b0;
            else if (level_en[g])
               irr_q[g] <= irq_in[g];
            else
               irr_q[g] <= irq_in[g] & (irr_q[g] | ~prev_q[g]);
         end
      end
   end

endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
   parameter int N     = 8,
   localparam int LVL_W = $clog2(N)
)(
   input  logic [N-1:0]      irr,
   input  logic [N-1:0]      imr,
   input  logic [N-1:0]      isr,
   output logic              have_req,
   output logic [LVL_W-1:0]  win_lvl
);

   logic [N-1:0] blocked;
   logic [N-1:0] eligible;

   // a level is blocked by any in-service bit at equal or higher priority
   assign blocked[0] = isr[0];
   for (genvar g = 1; g < N; g++) begin : g_blk
      assign blocked[g] = blocked[g-1] | isr[g];
   end

   assign eligible = irr & ~imr & ~blocked;

   always_comb begin
      have_req = 1'b0;
      win_lvl  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (eligible[i]) begin
            have_req = 1'b1;
            win_lvl  = LVL_W'(i);
         end
      end
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import pic_pkg::*;
#(
   parameter int             N         = 8,
   parameter int             DW        = 8,
   parameter bit             IS_MASTER = 1'b1,
   parameter logic [DW-1:0]  RST_MASK  = '1,
   localparam int            LVL_W     = $clog2(N),
   localparam int            BASE_W    = DW - LVL_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic [N-1:0]      irq_in,
   input  logic [N-1:0]      level_en,
   output logic              int_out,
   input  logic              ack,
   output logic [DW-1:0]     vector,
   output logic              vector_valid,
   input  logic [LVL_W-1:0]  cas_in,
   input  logic              cas_sel,
   output logic [LVL_W-1:0]  cas_out,
   output logic              cas_valid
);

   if (N != DW) begin : g_bad_width
      $error("prio_irq_ctrl: N must equal DW");
   end
   if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
      $error("prio_irq_ctrl: N must be a power of two");
   end

   localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(N - 1);

   logic [DW-1:0]     imr_q;
   logic [BASE_W-1:0] base_q;
   logic [DW-1:0]     casc_q;
   logic              auto_q;
   logic              rd_isr_q;
   logic              eoi_stb;
   logic [LVL_W-1:0]  eoi_lvl;
   logic              init_stb;

   logic [N-1:0]      irr_q;
   logic [N-1:0]      isr_q;
   logic              have_req;
   logic [LVL_W-1:0]  win_lvl;
   logic              ack_eff;
   logic              win_cascaded;
   logic [N-1:0]      win_vec;
   logic [N-1:0]      clr_vec;
   logic [N-1:0]      set_vec;
   logic [N-1:0]      eoi_vec;
   logic [DW-1:0]     vec_q;
   logic              vv_q;

   pic_regport #(.DW(DW), .RST_MASK(RST_MASK)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .imr_q    (imr_q),
      .base_q   (base_q),
      .casc_q   (casc_q),
      .auto_q   (auto_q),
      .rd_isr_q (rd_isr_q),
      .eoi_stb  (eoi_stb),
      .eoi_lvl  (eoi_lvl),
      .init_stb (init_stb)
   );

   pic_req_capture #(.N(N)) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_in   (irq_in),
      .level_en (level_en),
      .clr_vec  (clr_vec),
      .irr_q    (irr_q)
   );

   pic_prio #(.N(N)) u_prio (
      .irr      (irr_q),
      .imr      (imr_q),
      .isr      (isr_q),
      .have_req (have_req),
      .win_lvl  (win_lvl)
   );

   // role-dependent acknowledge qualification and cascade code
   if (IS_MASTER) begin : g_master
      assign ack_eff      = ack;
      assign win_cascaded = casc_q[win_lvl];
      assign cas_out      = win_lvl;
      assign cas_valid    = ack && have_req && casc_q[win_lvl];
   end else begin : g_slave
      assign ack_eff      = ack && cas_sel && (cas_in == casc_q[LVL_W-1:0]);
      assign win_cascaded = 1'b0;
      assign cas_out      = '0;
      assign cas_valid    = 1'b0;
   end

   assign win_vec = N'(1) << win_lvl;
   assign clr_vec = (ack_eff && have_req) ? win_vec : '0;
   assign set_vec = (ack_eff && have_req && !auto_q) ? win_vec : '0;
   assign eoi_vec = eoi_stb ? (N'(1) << eoi_lvl) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_q <= '0;
         vec_q <= '0;
         vv_q  <= 1'b0;
      end else begin
         if (init_stb)
            isr_q <= '0;
         else
            isr_q <= (isr_q & ~eoi_vec) | set_vec;

         vv_q <= 1'b0;
         if (ack_eff) begin
            if (have_req) begin
               vv_q  <= !win_cascaded;
               vec_q <= {base_q, win_lvl};
            end else begin
               vv_q  <= 1'b1;
               vec_q <= {base_q, SPUR_LVL};
            end
         end
      end
   end

   assign int_out      = have_req;
   assign vector       = vec_q;
   assign vector_valid = vv_q;
   assign rdata        = (addr == ADDR_DATA) ? imr_q : (rd_isr_q ? isr_q : irr_q);

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int N  = 8,
   parameter int DW = 8,
   localparam int LVL_W = $clog2(N)
)(
   input logic              clk,
   input logic              rst_n,
   input logic              ack_eff,
   input logic              have_req,
   input logic              int_out,
   input logic [N-1:0]      irr_q,
   input logic [DW-1:0]     imr_q,
   input logic [N-1:0]      isr_q,
   input logic              auto_q,
   input logic              eoi_stb,
   input logic [LVL_W-1:0]  eoi_lvl,
   input logic              vector_valid,
   input logic [DW-1:0]     vector
);

   assert_int_needs_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> ((irr_q & ~imr_q) != '0));

   assert_isr_only_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((isr_q & ~$past(isr_q)) != '0) |-> $past(ack_eff));

   assert_auto_sets_nothing_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_q && ack_eff) |=> ((isr_q & ~$past(isr_q)) == '0));

   assert_eoi_clears_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_stb && !ack_eff) |=> (isr_q == ($past(isr_q) & ~(N'(1) << $past(eoi_lvl)))));

   assert_spurious_level7_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_eff && !have_req) |=> (vector_valid && (vector[LVL_W-1:0] == LVL_W'(N - 1))));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N(N), .DW(DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ack_eff      (ack_eff),
   .have_req     (have_req),
   .int_out      (int_out),
   .irr_q        (irr_q),
   .imr_q        (imr_q),
   .isr_q        (isr_q),
   .auto_q       (auto_q),
   .eoi_stb      (eoi_stb),
   .eoi_lvl      (eoi_lvl),
   .vector_valid (vector_valid),
   .vector       (vector)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_wr = 1'b0, s_wr = 1'b0;
   logic       addr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] m_rdata, s_rdata;
   logic [7:0] mirq = '0, sirq = '0;
   logic [7:0] m_lvl = '0;
   logic       ack = 1'b0;
   logic       m_int, s_int;
   logic [7:0] m_vec, s_vec;
   logic       m_vv, s_vv;
   logic [2:0] m_cas, s_cas;
   logic       m_casv, s_casv;
   logic [7:0] m_irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   assign m_irq = {mirq[7:3], s_int, mirq[1:0]};

   prio_irq_ctrl #(.IS_MASTER(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(m_wr), .addr(addr), .wdata(wdata),
      .rdata(m_rdata), .irq_in(m_irq), .level_en(m_lvl), .int_out(m_int),
      .ack(ack), .vector(m_vec), .vector_valid(m_vv),
      .cas_in(3'd0), .cas_sel(1'b0), .cas_out(m_cas), .cas_valid(m_casv));

   prio_irq_ctrl #(.IS_MASTER(1'b0)) u_slave (
      .clk(clk), .rst_n(rst_n), .wr_en(s_wr), .addr(addr), .wdata(wdata),
      .rdata(s_rdata), .irq_in(sirq), .level_en(8'h00), .int_out(s_int),
      .ack(ack), .vector(s_vec), .vector_valid(s_vv),
      .cas_in(m_cas), .cas_sel(m_casv), .cas_out(s_cas), .cas_valid(s_casv));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input bit to_slave, input logic a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d;
      if (to_slave) s_wr = 1'b1; else m_wr = 1'b1;
      @(negedge clk);
      m_wr = 1'b0; s_wr = 1'b0;
   endtask

   task automatic rd(input bit from_slave, input logic a, output logic [7:0] d);
      addr = a;
      #1;
      d = from_slave ? s_rdata : m_rdata;
   endtask

   task automatic do_ack(output logic vv, output logic [7:0] v);
      @(negedge clk);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      vv = m_vv | s_vv;
      v  = m_vv ? m_vec : s_vec;
   endtask

   function automatic logic [7:0] exp_vec(input logic [7:0] req, input logic [7:0] msk);
      logic [7:0] e = req & ~msk;
      for (int i = 0; i < 8; i++) if (e[i]) return 8'h20 | 8'(i);
      return 8'h27;
   endfunction

   initial begin
      repeat (60000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] r;
      logic       vv;
      logic [7:0] v;
      void'($urandom(32'd2024));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(!m_int, "R1 int_out", m_int, 0);
      rd(0, 1'b1, r); chk(r == 8'hFF, "R1 mask", r, 8'hFF);
      rd(0, 1'b0, r); chk(r == 8'h00, "R1 request reg", r, 0);

      // R2 configuration sequence
      wr(0, 1'b0, 8'h11); wr(0, 1'b1, 8'h20); wr(0, 1'b1, 8'h04); wr(0, 1'b1, 8'h01);
      wr(1, 1'b0, 8'h11); wr(1, 1'b1, 8'h28); wr(1, 1'b1, 8'h02); wr(1, 1'b1, 8'h01);
      rd(0, 1'b1, r); chk(r == 8'hFF, "R2 mask untouched by config", r, 8'hFF);

      // R4 mask load and readback
      wr(0, 1'b1, 8'h00); wr(1, 1'b1, 8'h00);
      rd(0, 1'b1, r); chk(r == 8'h00, "R4 master mask", r, 0);
      rd(1, 1'b1, r); chk(r == 8'h00, "R4 slave mask", r, 0);

      // R12 spurious with no request
      do_ack(vv, v);
      chk(vv && v == 8'h27, "R12 spurious vector", v, 8'h27);
      wr(0, 1'b0, 8'h0B);
      rd(0, 1'b0, r); chk(r == 8'h00, "R12 no isr on spurious", r, 0);

      // R6 / R3 / R8 edge request on level 5
      mirq[5] = 1'b1; @(negedge clk);
      chk(m_int, "R6 edge latch", m_int, 1);
      do_ack(vv, v);
      chk(vv && v == 8'h25, "R3 R8 vector level5", v, 8'h25);
      rd(0, 1'b0, r); chk(r == 8'h20, "R8 isr set", r, 8'h20);
      wr(0, 1'b0, 8'h0A);
      rd(0, 1'b0, r); chk(r == 8'h00, "R8 request cleared", r, 0);
      wr(0, 1'b0, 8'h65);
      wr(0, 1'b0, 8'h0B);
      rd(0, 1'b0, r); chk(r == 8'h00, "R10 eoi level5", r, 0);
      chk(!m_int, "R6 steady high no re-request", m_int, 0);
      mirq[5] = 1'b0; @(negedge clk);

      // R6 / R12 request withdrawn before acknowledge
      mirq[4] = 1'b1; @(negedge clk);
      mirq[4] = 1'b0; @(negedge clk);
      chk(!m_int, "R6 falling line clears request", m_int, 0);
      do_ack(vv, v);
      chk(vv && v == 8'h27, "R12 withdrawn request", v, 8'h27);

      // R5 fixed priority and nesting
      mirq[3] = 1'b1; mirq[6] = 1'b1; @(negedge clk);
      do_ack(vv, v);
      chk(v == 8'h23, "R5 level3 wins", v, 8'h23);
      chk(!m_int, "R5 level6 blocked by isr3", m_int, 0);
      mirq[1] = 1'b1; @(negedge clk);
      chk(m_int, "R5 level1 preempts", m_int, 1);
      do_ack(vv, v);
      chk(v == 8'h21, "R5 level1 vector", v, 8'h21);
      rd(0, 1'b0, r); chk(r == 8'h0A, "R11 isr selected", r, 8'h0A);
      wr(0, 1'b1, 8'h00);
      rd(0, 1'b0, r); chk(r == 8'h0A, "R11 selection persists", r, 8'h0A);
      wr(0, 1'b0, 8'h63);
      rd(0, 1'b0, r); chk(r == 8'h02, "R10 only level3 cleared", r, 8'h02);
      wr(0, 1'b0, 8'h61);
      chk(m_int, "R5 level6 after eoi", m_int, 1);
      do_ack(vv, v);
      chk(v == 8'h26, "R5 level6 vector", v, 8'h26);
      wr(0, 1'b0, 8'h66);
      mirq = '0;
      wr(0, 1'b0, 8'h0A);
      rd(0, 1'b0, r); chk(r == 8'h00, "R11 request selected", r, 0);

      // R4 masked input recorded, R12 spurious with level 7 masked
      wr(0, 1'b1, 8'h90);
      mirq[4] = 1'b1; @(negedge clk);
      chk(!m_int, "R4 masked no int", m_int, 0);
      rd(0, 1'b0, r); chk(r == 8'h10, "R4 masked still recorded", r, 8'h10);
      mirq[4] = 1'b0; @(negedge clk);
      do_ack(vv, v);
      chk(vv && v == 8'h27, "R12 level7 masked", v, 8'h27);
      wr(0, 1'b1, 8'h00);

      // R7 level mode re-request
      m_lvl[6] = 1'b1; mirq[6] = 1'b1; @(negedge clk);
      do_ack(vv, v);
      chk(v == 8'h26, "R7 level vector", v, 8'h26);
      wr(0, 1'b0, 8'h66);
      chk(m_int, "R7 level re-requests", m_int, 1);
      do_ack(vv, v);
      chk(v == 8'h26, "R7 second vector", v, 8'h26);
      wr(0, 1'b0, 8'h66);
      mirq[6] = 1'b0; m_lvl = '0; @(negedge clk); @(negedge clk);
      chk(!m_int, "R7 line low", m_int, 0);

      // R9 automatic end of interrupt
      wr(0, 1'b0, 8'h11); wr(0, 1'b1, 8'h20); wr(0, 1'b1, 8'h04); wr(0, 1'b1, 8'h03);
      rd(0, 1'b1, r); chk(r == 8'h00, "R2 mask kept over reconfig", r, 0);
      wr(0, 1'b0, 8'h0B);
      mirq[5] = 1'b1; @(negedge clk);
      do_ack(vv, v);
      chk(v == 8'h25, "R9 vector", v, 8'h25);
      rd(0, 1'b0, r); chk(r == 8'h00, "R9 no isr", r, 0);
      mirq[5] = 1'b0;
      wr(0, 1'b0, 8'h11); wr(0, 1'b1, 8'h20); wr(0, 1'b1, 8'h04); wr(0, 1'b1, 8'h01);

      // R13 cascade through master input 2
      wr(0, 1'b0, 8'h0B); wr(1, 1'b0, 8'h0B);
      sirq[3] = 1'b1; @(negedge clk); @(negedge clk);
      chk(m_int, "R13 master sees slave", m_int, 1);
      do_ack(vv, v);
      chk(vv && v == 8'h2B && !m_vv, "R13 slave vector", v, 8'h2B);
      rd(0, 1'b0, r); chk(r == 8'h04, "R13 master isr", r, 8'h04);
      rd(1, 1'b0, r); chk(r == 8'h08, "R13 slave isr", r, 8'h08);
      wr(1, 1'b0, 8'h63);
      rd(1, 1'b0, r); chk(r == 8'h00, "R13 slave eoi", r, 0);
      rd(0, 1'b0, r); chk(r == 8'h04, "R13 master still in service", r, 8'h04);
      wr(0, 1'b0, 8'h62);
      rd(0, 1'b0, r); chk(r == 8'h00, "R13 master eoi", r, 0);
      sirq = '0;

      // random priority/mask mix in level mode, cascade input kept masked
      m_lvl = 8'hFB;
      for (int it = 0; it < 40; it++) begin
         logic [7:0] rq, mk, ev;
         rq = 8'($urandom) & 8'hFB;
         mk = 8'($urandom) | 8'h04;
         wr(0, 1'b1, mk);
         mirq = rq; @(negedge clk);
         ev = exp_vec(rq, mk);
         chk(m_int == ((rq & ~mk) != 0), "R5 random int_out", m_int, ((rq & ~mk) != 0));
         do_ack(vv, v);
         chk(vv && v == ev, "R5 random vector", v, ev);
         if (ev != 8'h27 || (rq & ~mk & 8'h80) != 0) begin
            rd(0, 1'b0, r);
            chk(r == (8'h01 << ev[2:0]), "R8 random isr", r, 8'h01 << ev[2:0]);
            wr(0, 1'b0, 8'h60 | {5'd0, ev[2:0]});
         end
         rd(0, 1'b0, r); chk(r == 8'h00, "R10 random isr cleared", r, 0);
         mirq = '0; @(negedge clk);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule